// File: doc/BRIEF.md
# Quasi-Bidirectional General-Purpose Port

This block is an 8-bit general-purpose port of the kind found next to a small microcontroller core. Each bit keeps an output value in a register that the internal bus writes. A zero in that register switches on a strong pull-down on the pin. A one releases the pull-down, and the pin then rests high through a weak pull-up, or through an external resistor in the open-drain variant. No direction register exists. Software turns a bit into an input by writing a one to it. From then on, an external device may pull the pin low or leave it high.

The bus reads the port in two ways. A read of the stored register value is used by read-modify-write sequences, so that a bit held low from outside does not corrupt the value written back. A read of the live pin level is used by plain reads. The level is taken through a two-stage synchronizer so that asynchronous pin activity cannot make the read data metastable. Both reads are registered. A one-cycle valid pulse marks each completed read.

Top module: `qbio_port`

## Requirements
- R1: After reset, every bit of the output register is 1. `pin_oe` is all 0, `rd_valid` is 0 and `rd_data` is 0.
- R2: When `wr_en` is high at a clock edge, the output register takes `wr_data` at that edge.
- R3: A register bit of 0 sets its `pin_oe` bit to 1 with `pin_o` 0, which drives the pin low. A register bit of 1 clears `pin_oe`.
- R4: With `OPEN_DRAIN`=0, `pin_pu` equals the register value, so a released bit is weakly pulled high. With `OPEN_DRAIN`=1, `pin_pu` is always 0. `pin_pu` and `pin_oe` are never both 1 on the same bit.
- R5: A `rd_pin` strobe at clock edge M loads `rd_data` with the level that `pin_i` had at edge M-2, which is the result of the two-stage synchronizer.
- R6: A `rd_latch` strobe loads `rd_data` with the register value, whatever the pin level is.
- R7: When `rd_latch` and `rd_pin` are high together, the register value is returned.
- R8: `rd_valid` is high in the cycle after any read strobe and low in the cycle after a cycle with no read strobe.
- R9: A bit whose register holds 0 reads 0 on a pin read even when an external source drives it high. A bit works as an input only after a 1 has been written to it.
- R10: A write and a `rd_latch` in the same cycle return the register value from before the write.
- R11: `rd_data` keeps its value in cycles with no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe to the output register |
| wr_data | input | WIDTH | Bus write data |
| rd_latch | input | 1 | Read strobe for the register value |
| rd_pin | input | 1 | Read strobe for the synchronized pin level |
| pin_i | input | WIDTH | Sampled pad level |
| pin_o | output | WIDTH | Level driven while pin_oe is set (always low) |
| pin_oe | output | WIDTH | Strong pull-down enable per bit |
| pin_pu | output | WIDTH | Weak pull-up enable per bit |
| rd_data | output | WIDTH | Registered read result |
| rd_valid | output | 1 | One-cycle pulse after a read strobe |

## Verification
In the bench, each pad resolves as a wired-AND of the port pull-down and an optional external driver, and it idles at a weak high. The port is tried with several patterns. Mixed register values are read back against pins driven all high, which tells a forced-low bit apart from a true input. A register of all ones is read with external patterns, so the register path and the pin path return different words. A pin change is followed by back-to-back pin reads, which fixes the exact synchronizer latency. Coincident strobes and a write that coincides with a register read set the ordering at each edge. A random phase follows, with a behavioural model compared on every clock.

// File: rtl/qbio_pkg.sv
package qbio_pkg;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_PIN   = 2'd1,
    SRC_LATCH = 2'd2
  } rd_src_e;

  // Register path wins so that read-modify-write sees stored values.
  function automatic rd_src_e pick_source(input logic want_latch, input logic want_pin);
    if (want_latch)    return SRC_LATCH;
    else if (want_pin) return SRC_PIN;
    else               return SRC_NONE;
  endfunction

  // Weak pull-up for one bit: only when released and not open-drain.
  function automatic logic pull_for(input logic stored, input logic open_drain);
    return stored & ~open_drain;
  endfunction

endpackage

// File: rtl/qbio_out_bank.sv
module qbio_out_bank #(
  parameter int              WIDTH      = 8,
  parameter bit              OPEN_DRAIN = 1'b0,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] store_q,
  output logic [WIDTH-1:0] pin_o,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_pu
);
  import qbio_pkg::*;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic bit_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bit_q <= RESET_VAL[b];
      else if (wr_en) bit_q <= wr_data[b];
    end

    assign store_q[b] = bit_q;
    assign pin_o[b]   = 1'b0;
    assign pin_oe[b]  = ~bit_q;
    assign pin_pu[b]  = pull_for(bit_q, OPEN_DRAIN);
  end
endmodule

// File: rtl/qbio_sync.sv
module qbio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '1;
        else        stg[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '1;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign sync_o = stg[LAST];
endmodule

// File: rtl/qbio_read_path.sv
module qbio_read_path #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_latch,
  input  logic             rd_pin,
  input  logic [WIDTH-1:0] store_q,
  input  logic [WIDTH-1:0] pin_sync,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid
);
  import qbio_pkg::*;

  rd_src_e          src;
  logic [WIDTH-1:0] next_data;

  always_comb begin
    src = pick_source(rd_latch, rd_pin);
    unique case (src)
      SRC_LATCH: next_data = store_q;
      SRC_PIN:   next_data = pin_sync;
      default:   next_data = rd_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_data  <= next_data;
      rd_valid <= (src != SRC_NONE);
    end
  end
endmodule

// File: rtl/qbio_port.sv
module qbio_port #(
  parameter int               WIDTH       = 8,
  parameter int               SYNC_STAGES = 2,
  parameter bit               OPEN_DRAIN  = 1'b0,
  parameter logic [WIDTH-1:0] RESET_VAL   = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_latch,
  input  logic             rd_pin,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_o,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_pu,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid
);
  // Named internal events for the checker.
  logic [WIDTH-1:0] store_q;
  logic [WIDTH-1:0] pin_sync;
  logic             any_read;

  assign any_read = rd_latch | rd_pin;

  qbio_out_bank #(
    .WIDTH(WIDTH), .OPEN_DRAIN(OPEN_DRAIN), .RESET_VAL(RESET_VAL)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .store_q(store_q), .pin_o(pin_o), .pin_oe(pin_oe), .pin_pu(pin_pu)
  );

  qbio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pin_i), .sync_o(pin_sync)
  );

  qbio_read_path #(.WIDTH(WIDTH)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_latch(rd_latch), .rd_pin(rd_pin),
    .store_q(store_q), .pin_sync(pin_sync),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/qbio_port_chk.sv
module qbio_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [WIDTH-1:0] wr_data,
  input logic             rd_latch,
  input logic             rd_pin,
  input logic             any_read,
  input logic [WIDTH-1:0] store_q,
  input logic [WIDTH-1:0] pin_sync,
  input logic [WIDTH-1:0] pin_oe,
  input logic [WIDTH-1:0] pin_pu,
  input logic [WIDTH-1:0] rd_data,
  input logic             rd_valid
);
  // R2
  write_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> store_q == $past(wr_data));

  // R3
  drive_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pin_oe == ~$past(wr_data));

  // R4
  no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & pin_pu) == '0);

  // R5
  pin_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pin && !rd_latch) |=> rd_data == $past(pin_sync));

  // R6
  latch_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_latch |=> rd_data == $past(store_q));

  // R8
  valid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_read |=> rd_valid);

  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_read |=> !rd_valid);

  // R11
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_latch || rd_pin) |=> $stable(rd_data));
endmodule

bind qbio_port qbio_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_latch(rd_latch), .rd_pin(rd_pin), .any_read(any_read),
  .store_q(store_q), .pin_sync(pin_sync), .pin_oe(pin_oe), .pin_pu(pin_pu),
  .rd_data(rd_data), .rd_valid(rd_valid)
);

// File: tb/qbio_port_test.sv
module qbio_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_latch = 1'b0;
  logic       rd_pin = 1'b0;
  logic [7:0] ext_oe = '0;
  logic [7:0] ext_val = '0;
  logic [7:0] pin_i, pin_o, pin_oe, pin_pu, rd_data;
  logic       rd_valid;
  logic [7:0] od_pin, od_o, od_oe, od_pu, od_rd;
  logic       od_valid;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // Pad: wired-AND of port pull-down and external source, weak high at rest.
  assign pin_i  = ~(pin_oe & ~pin_o) & ((ext_oe & ext_val) | ~ext_oe);
  assign od_pin = ~(od_oe & ~od_o);

  qbio_port uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_latch(rd_latch), .rd_pin(rd_pin), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe(pin_oe), .pin_pu(pin_pu),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  qbio_port #(.OPEN_DRAIN(1'b1)) uut_od (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_latch(rd_latch), .rd_pin(rd_pin), .pin_i(od_pin),
    .pin_o(od_o), .pin_oe(od_oe), .pin_pu(od_pu),
    .rd_data(od_rd), .rd_valid(od_valid)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: stored word, pad history queue, read result.
  logic [7:0] m_store = 8'hFF;
  logic [7:0] m_rd = 8'h00;
  logic       m_valid = 1'b0;
  logic [7:0] hist[$] = '{8'hFF, 8'hFF};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_store <= 8'hFF; m_rd <= 8'h00; m_valid <= 1'b0;
      hist = '{8'hFF, 8'hFF};
    end else begin
      if (rd_latch)    m_rd <= m_store;
      else if (rd_pin) m_rd <= hist[1];
      m_valid <= rd_latch | rd_pin;
      if (wr_en) m_store <= wr_data;
      hist.push_front(pin_i);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5/R6 model rd_data", rd_data, m_rd);
      chk("R8 model rd_valid", {7'd0, rd_valid}, {7'd0, m_valid});
      chk("R3 model pin_oe", pin_oe, ~m_store);
      chk("R4 model pin_pu", pin_pu, m_store);
      chk("R4 open-drain pull-up", od_pu, 8'h00);
    end
  end

  task automatic drive(input logic w, input logic [7:0] d, input logic rl, input logic rp);
    wr_en = w; wr_data = d; rd_latch = rl; rd_pin = rp;
    @(negedge clk);
    wr_en = 1'b0; rd_latch = 1'b0; rd_pin = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    chk("R1 pin_oe at reset", pin_oe, 8'h00);
    chk("R1 rd_data at reset", rd_data, 8'h00);
    chk("R1 rd_valid at reset", {7'd0, rd_valid}, 8'h00);
    rst_n = 1'b1;
    idle(1);
    drive(0, 0, 1, 0);
    chk("R1 register all ones", rd_data, 8'hFF);

    // R2 R3 R4: mixed word
    drive(1, 8'h5A, 0, 0);
    chk("R3 pin_oe after write", pin_oe, 8'hA5);
    chk("R3 pin_o low", pin_o, 8'h00);
    chk("R4 weak pull-up", pin_pu, 8'h5A);
    chk("R4 open-drain no pull-up", od_pu, 8'h00);
    drive(0, 0, 1, 0);
    chk("R2 R6 register read", rd_data, 8'h5A);
    chk("R8 valid after read", {7'd0, rd_valid}, 8'h01);
    idle(1);
    chk("R8 valid drops", {7'd0, rd_valid}, 8'h00);
    chk("R11 data held", rd_data, 8'h5A);

    // R9: external high cannot lift a pulled-down bit
    ext_oe = 8'hFF; ext_val = 8'hFF;
    idle(3);
    drive(0, 0, 0, 1);
    chk("R9 forced-low bits read 0", rd_data, 8'h5A);

    // R5 R6: all inputs, external pattern
    drive(1, 8'hFF, 0, 0);
    ext_val = 8'h3C;
    idle(3);
    drive(0, 0, 0, 1);
    chk("R5 pin read", rd_data, 8'h3C);
    drive(0, 0, 1, 0);
    chk("R6 register read ignores pin", rd_data, 8'hFF);

    // R5: synchronizer latency
    ext_val = 8'hC3;
    drive(0, 0, 0, 1);
    chk("R5 latency edge 1", rd_data, 8'h3C);
    drive(0, 0, 0, 1);
    chk("R5 latency edge 2", rd_data, 8'h3C);
    drive(0, 0, 0, 1);
    chk("R5 latency edge 3", rd_data, 8'hC3);

    // R7: both strobes
    drive(0, 0, 1, 1);
    chk("R7 register wins", rd_data, 8'hFF);

    // R10: write with register read
    drive(1, 8'h00, 1, 0);
    chk("R10 old value returned", rd_data, 8'hFF);
    drive(0, 0, 1, 0);
    chk("R10 new value next", rd_data, 8'h00);
    idle(3);
    drive(0, 0, 0, 1);
    chk("R9 all forced low", rd_data, 8'h00);

    // Random phase, model compared each clock
    for (int i = 0; i < 400; i++) begin
      ext_oe  = 8'($urandom);
      ext_val = 8'($urandom);
      drive(1'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule